// File: doc/BRIEF.md
# Receive FIFO Auto-RTS Hysteresis Controller

This block sits between a UART's receive shift register and the host. Each completed character is pushed with its three error tags into a 64-entry queue, and the host pops entries in arrival order. The fill level is compared with one of four software-selected receive levels, which are 8, 16, 56 and 60 characters. A data-ready request goes out whenever the queue holds at least the selected level.

The active-low request-to-send output can run in automatic mode. In that mode it does not switch at the selected level. It goes inactive (high) at the next higher table level and becomes active (low) again at the next lower table level. This gap keeps the remote transmitter from being switched on and off on every character near the threshold. Automatic mode takes effect only when its enable is set and software drives the modem-control request bit high. Otherwise the pin follows that bit.

When the RTS pin goes from low to high, an optional sticky interrupt flag can be raised. The host clears it by reading status.

Top module: `rxq_rts_hyst`

## Requirements
- R1: Entries come out in the order they were written. Each entry keeps its 8 data bits and its 3 tag bits. Read data is valid from the cycle after the read request.
- R2: `rx_count` reports the number of stored entries, from 0 to 64. A read and a write in the same cycle on a non-empty queue leave the count unchanged, and this includes a full queue.
- R3: A write to a full queue with no read in the same cycle is dropped. The count stays at 64 and `overrun` is set. `overrun` stays set until reset.
- R4: A read from an empty queue leaves the count at 0 and leaves the read data at its last value.
- R5: `data_ready` is high exactly when the count is at least the selected level. `trig_sel` values 0, 1, 2 and 3 select 8, 16, 56 and 60.
- R6: When `auto_rts_en` is low or `rts_req` is low, `rts_n` equals the inverse of `rts_req` in the same cycle.
- R7: In automatic mode, `rts_n` goes high one cycle after the count reaches the upper mark. The upper marks for selections 0, 1, 2 and 3 are 16, 56, 60 and 60.
- R8: In automatic mode, `rts_n` goes low one cycle after the count is at or below the lower mark. The lower marks for selections 0, 1, 2 and 3 are 0, 8, 16 and 56. Between the two marks, `rts_n` keeps its value.
- R9: After `rts_n` goes high, the queue keeps accepting writes until it holds 64 entries.
- R10: When `rts_irq_en` is set and `rts_n` rises, `rts_irq` is set on the next cycle. It holds until a `stat_rd` pulse clears it. A new rise in the same cycle as the clear wins.
- R11: A change of `trig_sel` applies the new marks from the next cycle, using the current count. If the count lies between the new marks, `rts_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push one received character |
| wr_data | input | 8 | Received data byte |
| wr_tags | input | 3 | Error tags of the received byte |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Data of the last popped entry |
| rd_tags | output | 3 | Tags of the last popped entry |
| trig_sel | input | 2 | Receive level select (8/16/56/60) |
| auto_rts_en | input | 1 | Enables automatic RTS |
| rts_req | input | 1 | Modem-control request-to-send bit |
| rts_irq_en | input | 1 | Enables the RTS rise interrupt |
| stat_rd | input | 1 | Status read pulse that clears the interrupt flag |
| rx_count | output | 7 | Number of stored entries |
| data_ready | output | 1 | Count is at or above the selected level |
| rts_n | output | 1 | Active-low request-to-send pin |
| rts_irq | output | 1 | Sticky RTS rise flag |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
A wrong hysteresis state appears on `rts_n` one cycle after the count crosses a mark. The same error also delays or adds an `rts_irq` one cycle after that. A corrupted pointer or count appears as out-of-order or wrong read data on the next pop. It also makes `data_ready` switch at the wrong fill level. The bench sweeps every fill level up to 64 and back down to 0 for each of the four selections, so a mark that is off by one is caught at the first level where it matters.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;
  localparam int LVL_TOP = 60;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [TAG_W-1:0]  tags;
  } rx_entry_t;

  // receive level for a selection
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  // next table level above the selection; the top entry saturates
  function automatic int upper_mark(input logic [1:0] sel);
    if (sel == 2'd3) return LVL_TOP;
    return trig_level(sel + 2'd1);
  endfunction

  // next table level below the selection; the bottom entry means empty
  function automatic int lower_mark(input logic [1:0] sel);
    if (sel == 2'd0) return 0;
    return trig_level(sel - 2'd1);
  endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  rx_entry_t     wr_entry,
  input  logic          rd_req,
  output rx_entry_t     rd_entry,
  output logic [CW-1:0] count,
  output logic          overrun,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop
);
  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = rd_req && !empty;
  assign push_ok = wr_req && (!full || pop_ok);
  assign drop    = wr_req && !push_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_entry <= '0;
      overrun  <= 1'b0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok) begin
        rd_entry <= mem[rptr];
        rptr     <= bump(rptr);
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_rts_ctl.sv
`timescale 1ns/1ps
module rxq_rts_ctl
  import rxq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    sel,
  input  logic          auto_en,
  input  logic          rts_req,
  output logic [CW-1:0] hi_mark,
  output logic [CW-1:0] lo_mark,
  output logic          hold_off,
  output logic          rts_n
);
  logic live;

  assign live    = auto_en && rts_req;
  assign hi_mark = CW'(upper_mark(sel));
  assign lo_mark = CW'(lower_mark(sel));

  always_ff @(posedge clk) begin
    if (!rst_n)                hold_off <= 1'b0;
    else if (!live)            hold_off <= 1'b0;
    else if (count >= hi_mark) hold_off <= 1'b1;
    else if (count <= lo_mark) hold_off <= 1'b0;
  end

  assign rts_n = live ? hold_off : !rts_req;
endmodule

// File: rtl/rxq_rts_irq.sv
`timescale 1ns/1ps
module rxq_rts_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_n,
  input  logic irq_en,
  input  logic stat_rd,
  output logic rise,
  output logic flag
);
  logic rts_n_q;

  assign rise = rts_n && !rts_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_n_q <= 1'b1;
      flag    <= 1'b0;
    end else begin
      rts_n_q <= rts_n;
      if (irq_en && rise) flag <= 1'b1;
      else if (stat_rd)   flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_rts_hyst.sv
`timescale 1ns/1ps
module rxq_rts_hyst
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [2:0]    wr_tags,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [2:0]    rd_tags,
  input  logic [1:0]    trig_sel,
  input  logic          auto_rts_en,
  input  logic          rts_req,
  input  logic          rts_irq_en,
  input  logic          stat_rd,
  output logic [CW-1:0] rx_count,
  output logic          data_ready,
  output logic          rts_n,
  output logic          rts_irq,
  output logic          overrun
);
  rx_entry_t     in_entry, out_entry;
  logic          push_ok, pop_ok, drop, rts_rise, hold_off;
  logic [CW-1:0] hi_mark, lo_mark;

  assign in_entry = '{data: wr_data, tags: wr_tags};
  assign rd_data  = out_entry.data;
  assign rd_tags  = out_entry.tags;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .wr_entry(in_entry),
    .rd_req(rd_en), .rd_entry(out_entry), .count(rx_count),
    .overrun(overrun), .push_ok(push_ok), .pop_ok(pop_ok), .drop(drop)
  );

  assign data_ready = (rx_count >= CW'(trig_level(trig_sel)));

  rxq_rts_ctl #(.CW(CW)) u_rts (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .sel(trig_sel),
    .auto_en(auto_rts_en), .rts_req(rts_req), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .hold_off(hold_off), .rts_n(rts_n)
  );

  rxq_rts_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .irq_en(rts_irq_en),
    .stat_rd(stat_rd), .rise(rts_rise), .flag(rts_irq)
  );
endmodule

// File: rtl/rxq_rts_hyst_chk.sv
`timescale 1ns/1ps
module rxq_rts_hyst_chk
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    trig_sel,
  input logic          auto_rts_en,
  input logic          rts_req,
  input logic          rts_irq_en,
  input logic          stat_rd,
  input logic [CW-1:0] rx_count,
  input logic          data_ready,
  input logic          rts_n,
  input logic          rts_irq,
  input logic          overrun,
  input logic [CW-1:0] hi_mark,
  input logic [CW-1:0] lo_mark,
  input logic          push_ok
);
  logic live;
  assign live = auto_rts_en && rts_req;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));
  p_rdwr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && rx_count != '0) |=> $stable(rx_count));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && rx_count == CW'(DEPTH)) |=> (overrun && $stable(rx_count)));
  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && rx_count == '0) |=> (rx_count == '0));
  p_ready_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready == (rx_count >= CW'(trig_level(trig_sel))));
  p_manual_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (rts_n == !rts_req));
  p_deassert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rx_count >= hi_mark) |=> (!live || rts_n));
  p_reassert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rx_count <= lo_mark) |=> (!live || !rts_n));
  p_accept_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rx_count < CW'(DEPTH)) |-> push_ok);
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_irq_en && $rose(rts_n)) |=> rts_irq);
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_irq && !stat_rd) |=> rts_irq);
endmodule

bind rxq_rts_hyst rxq_rts_hyst_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .trig_sel(trig_sel), .auto_rts_en(auto_rts_en), .rts_req(rts_req),
  .rts_irq_en(rts_irq_en), .stat_rd(stat_rd), .rx_count(rx_count),
  .data_ready(data_ready), .rts_n(rts_n), .rts_irq(rts_irq),
  .overrun(overrun), .hi_mark(hi_mark), .lo_mark(lo_mark),
  .push_ok(push_ok)
);

// File: tb/rxq_rts_hyst_bench.sv
`timescale 1ns/1ps
module rxq_rts_hyst_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_tags = '0;
  logic [7:0] rd_data;
  logic [2:0] rd_tags;
  logic [1:0] trig_sel = '0;
  logic       auto_rts_en = 1'b0, rts_req = 1'b0, rts_irq_en = 1'b0, stat_rd = 1'b0;
  logic [6:0] rx_count;
  logic       data_ready, rts_n, rts_irq, overrun;

  int n_chk = 0, n_bad = 0;
  int lv[4] = '{8, 16, 56, 60};

  always #2.5 clk = ~clk;

  rxq_rts_hyst u_rxq_rts_hyst (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_tags(wr_tags), .rd_en(rd_en), .rd_data(rd_data), .rd_tags(rd_tags),
    .trig_sel(trig_sel), .auto_rts_en(auto_rts_en), .rts_req(rts_req),
    .rts_irq_en(rts_irq_en), .stat_rd(stat_rd), .rx_count(rx_count),
    .data_ready(data_ready), .rts_n(rts_n), .rts_irq(rts_irq),
    .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one operation, then let count, rts state and irq flag settle
  task automatic step(input logic w, input logic r, input logic [7:0] d, input logic [2:0] t);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d; wr_tags = t;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; rts_req = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat_d(int i, int s); return 8'((i * 37 + s * 11) & 255); endfunction
  function automatic logic [2:0] pat_t(int i, int s); return 3'((i + s) % 8); endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, hi, lo;
    logic off, prev;
    do_reset();
    chk("R2 reset count", rx_count, 0);
    chk("R6 reset rts_n", rts_n, 1);
    chk("R5 reset ready", data_ready, 0);
    chk("R3 reset overrun", overrun, 0);
    chk("R10 reset irq", rts_irq, 0);

    // sweep every fill level for each selection
    for (int s = 0; s < 4; s++) begin
      do_reset();
      trig_sel = 2'(s); auto_rts_en = 1'b1; rts_irq_en = 1'b1;
      @(negedge clk); rts_req = 1'b1;
      @(negedge clk);
      hi = (s == 3) ? 60 : lv[s + 1];
      lo = (s == 0) ? 0 : lv[s - 1];
      cnt = 0; off = 1'b0;
      chk("R6 auto start rts_n low", rts_n, 0);
      for (int i = 0; i < 64; i++) begin
        step(1'b1, 1'b0, pat_d(i, s), pat_t(i, s));
        cnt++; prev = off;
        if (cnt >= hi) off = 1'b1; else if (cnt <= lo) off = 1'b0;
        chk("R9 fill count", rx_count, cnt);
        chk("R5 ready at level", data_ready, int'(cnt >= lv[s]));
        chk("R7 rts_n on fill", rts_n, off);
        chk("R10 irq on rise", rts_irq, int'(off && !prev));
        if (off && !prev) begin
          clear_irq();
          chk("R10 irq cleared", rts_irq, 0);
        end
      end
      step(1'b1, 1'b0, 8'hEE, 3'd7);
      chk("R3 full drop count", rx_count, 64);
      chk("R3 overrun set", overrun, 1);
      step(1'b1, 1'b1, pat_d(64, s), pat_t(64, s));
      chk("R2 full rd+wr count", rx_count, 64);
      chk("R1 full rd+wr data", rd_data, pat_d(0, s));
      for (int i = 1; i <= 64; i++) begin
        step(1'b0, 1'b1, '0, '0);
        cnt--; prev = off;
        if (cnt >= hi) off = 1'b1; else if (cnt <= lo) off = 1'b0;
        chk("R1 order data", rd_data, pat_d(i, s));
        chk("R1 order tags", rd_tags, pat_t(i, s));
        chk("R2 drain count", rx_count, cnt);
        chk("R8 rts_n on drain", rts_n, off);
        chk("R5 ready on drain", data_ready, int'(cnt >= lv[s]));
      end
      step(1'b0, 1'b1, '0, '0);
      chk("R4 empty read count", rx_count, 0);
      chk("R4 empty read data", rd_data, pat_d(64, s));
      chk("R3 overrun sticky", overrun, 1);
    end

    // selection change with a held count
    do_reset();
    trig_sel = 2'd1; auto_rts_en = 1'b1; rts_irq_en = 1'b0;
    @(negedge clk); rts_req = 1'b1;
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 8'(i), 3'(i));
    chk("R11 band at sel1", rts_n, 0);
    step(1'b1, 1'b1, 8'h30, 3'd0);
    chk("R2 rd+wr mid count", rx_count, 30);
    chk("R1 rd+wr mid data", rd_data, 0);
    trig_sel = 2'd0; repeat (2) @(negedge clk);
    chk("R11 sel0 above upper", rts_n, 1);
    trig_sel = 2'd1; repeat (2) @(negedge clk);
    chk("R11 sel1 band holds high", rts_n, 1);
    trig_sel = 2'd2; repeat (2) @(negedge clk);
    chk("R11 sel2 band holds high", rts_n, 1);
    trig_sel = 2'd3; repeat (2) @(negedge clk);
    chk("R11 sel3 below lower", rts_n, 0);
    chk("R5 sel3 ready", data_ready, 0);

    // manual pin control
    auto_rts_en = 1'b0; rts_req = 1'b0; @(negedge clk);
    chk("R6 manual off", rts_n, 1);
    rts_req = 1'b1; @(negedge clk);
    chk("R6 manual on", rts_n, 0);
    trig_sel = 2'd0; repeat (2) @(negedge clk);
    chk("R6 manual ignores level", rts_n, 0);
    auto_rts_en = 1'b1; rts_req = 1'b0; @(negedge clk);
    chk("R6 auto without request", rts_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule